// File: doc/BRIEF.md
# UART Receive Frame Checker

This block recovers bytes from an asynchronous serial receive line. A 16x oversampling enable, produced elsewhere, paces a framing state machine. The machine confirms a start bit at mid-bit and gathers eight data bits, least significant first. It then reads an optional parity slot and checks the first stop bit. Each completed byte goes into a receive buffer together with a parity flag and a framing flag. Software-facing logic reads that buffer through a simple pop strobe.

The buffer has two modes, chosen by an input. In queue mode it holds several entries. In holding mode it holds a single character. The parity slot can be absent, checked as odd or even, compared against a fixed level, or read as an address marker in 9-bit mode. In 9-bit mode the marker is reported on the parity flag. A byte that finds the buffer full is discarded and raises a sticky overrun flag.

The framing machine has six states. RX_IDLE waits for a low line on a tick. RX_START counts to mid-bit, then moves to RX_DATA if the line is still low, or falls back to RX_IDLE. RX_DATA samples eight bits, one every 16 ticks, then moves to RX_PAR if a slot is configured, otherwise to RX_STOP. RX_PAR samples the slot and moves to RX_STOP. RX_STOP samples the stop level and stores the byte. It goes to RX_IDLE on a high level, or to RX_REARM on a low one. RX_REARM waits for the line to return high, then goes to RX_IDLE.

Top module: `uart_rx_frame_chk`

## Requirements
- R1: A low level that has gone high again at the eighth tick after the start was detected is a false start. It stores nothing and the outputs do not change.
- R2: With `fifo_en`=1 the buffer accepts up to DEPTH entries. With `fifo_en`=0 it accepts exactly one entry, and `buf_full` rises as soon as that entry is stored.
- R3: The eight data bits are sampled at their mid-points and assembled least significant bit first. The first bit after the start bit becomes `rd_data[0]`.
- R4: With `par_en`=0 and `nine_bit`=0 there is no parity slot. The stop bit directly follows data bit 7, and `rd_perr` is 0.
- R5: With `par_en`=1, `stick_sel`=0 and `nine_bit`=0, `even_sel`=1 demands an even count of ones over the data and slot bits, and `even_sel`=0 demands an odd count. A mismatch sets `rd_perr` for that byte.
- R6: With `par_en`=1, `stick_sel`=1 and `nine_bit`=0, the slot must read 1 when `even_sel`=0 and 0 when `even_sel`=1. Any other value sets `rd_perr`.
- R7: With `nine_bit`=1 a slot is always present, whatever `par_en` is. `rd_perr` equals the received slot bit, which marks an address byte.
- R8: `stop2` has no effect on reception. Only one stop bit is checked, so frames that follow each other with a single stop bit are all received without framing errors.
- R9: A low level at the first stop bit sets `rd_ferr` for that byte. The machine then waits for a high line before it accepts a new start bit.
- R10: A byte that completes while the buffer is full is discarded, and the stored entries stay unchanged. `rd_ovr` is set and stays set until the next successful read.
- R11: `rd_data`, `rd_perr` and `rd_ferr` show the oldest entry while `rd_valid`=1, and show 0 when the buffer is empty. `rd_en` with `rd_valid`=1 removes that entry. A byte that completes in the same cycle as a read from a full buffer is kept and does not count as an overrun.
- R12: During and after reset the buffer is empty, and `rd_valid`, `buf_full` and `rd_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding entry |
| stop2 | input | 1 | Two-stop-bit setting, which reception ignores |
| par_en | input | 1 | Parity slot present |
| even_sel | input | 1 | Parity sense, or stick level select |
| stick_sel | input | 1 | Fixed-level parity |
| nine_bit | input | 1 | Slot read as address marker |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 8 | Oldest byte |
| rd_perr | output | 1 | Parity error or address marker of oldest byte |
| rd_ferr | output | 1 | Framing error of oldest byte |
| rd_ovr | output | 1 | Sticky overrun flag |
| rd_valid | output | 1 | Buffer not empty |
| buf_full | output | 1 | Buffer at capacity for the current mode |

## Verification
The store of a completed byte and a software read can land in the same cycle. The delicate case is a full buffer, where the outcome decides between keeping and dropping the new byte. To provoke it, the bench holds one byte in holding mode and sends a second one. It repeats this while sliding a one-cycle read pulse across the stop-bit window. In every trial the read must return the first byte. Afterwards the buffer must either hold the second byte or be empty with the overrun flag cleared. The sweep must produce both outcomes, and the checker confirms that a coincident read and store keeps the fill level and raises no overrun.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_REARM
    } rx_state_t;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      par_en,
    input  logic      even_sel,
    input  logic      stick_sel,
    input  logic      nine_bit,
    output logic      push,
    output rx_entry_t entry
);

    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [CW-1:0] MID_LAST = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    rx_state_t         st;
    rx_state_t         st_nx;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [BYTE_W-1:0] shreg;
    logic              pbit;
    logic              slot;
    logic              mid_hit;
    logic              bit_hit;
    logic              perr_c;

    assign slot    = par_en | nine_bit;
    assign mid_hit = tick && (tcnt == MID_LAST);
    assign bit_hit = tick && (tcnt == BIT_LAST);

    // slot judgement: address marker, fixed level, or computed parity
    always_comb begin
        if (!slot) begin
            perr_c = 1'b0;
        end else if (nine_bit) begin
            perr_c = pbit;
        end else if (stick_sel) begin
            perr_c = (pbit == even_sel);
        end else if (even_sel) begin
            perr_c = ^{shreg, pbit};
        end else begin
            perr_c = ~(^{shreg, pbit});
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (tick && !rx) st_nx = RX_START;
            RX_START: if (mid_hit) st_nx = rx ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_hit && bidx == LAST_BIT) st_nx = slot ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_hit) st_nx = RX_STOP;
            RX_STOP:  if (bit_hit) st_nx = rx ? RX_IDLE : RX_REARM;
            RX_REARM: if (tick && rx) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    // counters, shifter and output strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            push  <= 1'b0;
            entry <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        tcnt <= '0;
                    end
                    RX_START: begin
                        tcnt <= mid_hit ? '0 : tcnt + 1'b1;
                        bidx <= '0;
                    end
                    RX_DATA: begin
                        tcnt <= bit_hit ? '0 : tcnt + 1'b1;
                        if (bit_hit) begin
                            shreg <= {rx, shreg[BYTE_W-1:1]};
                            bidx  <= bidx + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        tcnt <= bit_hit ? '0 : tcnt + 1'b1;
                        if (bit_hit) pbit <= rx;
                    end
                    RX_STOP: begin
                        tcnt <= bit_hit ? '0 : tcnt + 1'b1;
                        if (bit_hit) begin
                            push       <= 1'b1;
                            entry.data <= shreg;
                            entry.ferr <= ~rx;
                            entry.perr <= perr_c;
                        end
                    end
                    RX_REARM: begin
                        tcnt <= '0;
                    end
                    default: begin
                        tcnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/urx_rxbuf.sv
module urx_rxbuf
    import urx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  rx_entry_t     din,
    input  logic          pop,
    output rx_entry_t     dout,
    output logic          valid,
    output logic          full,
    output logic          ovr,
    output logic [FW-1:0] fill
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    rx_entry_t     rd_arr [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [FW-1:0] cap;
    logic          do_pop;
    logic          do_push;
    logic          drop;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign cap     = fifo_en ? FW'(DEPTH) : FW'(1);
    assign full    = (fill >= cap);
    assign valid   = (fill != '0);
    assign do_pop  = pop & valid;
    assign do_push = push & (~full | do_pop);
    assign drop    = push & full & ~do_pop;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rx_entry_t q;
        always_ff @(posedge clk) begin
            if (do_push && wptr == AW'(i)) begin
                q <= din;
            end
        end
        assign rd_arr[i] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
            ovr  <= 1'b0;
        end else begin
            if (do_push) wptr <= ptr_step(wptr);
            if (do_pop)  rptr <= ptr_step(rptr);
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
            if (drop) begin
                ovr <= 1'b1;
            end else if (do_pop) begin
                ovr <= 1'b0;
            end
        end
    end

    assign dout = valid ? rd_arr[rptr] : '0;

endmodule

// File: rtl/uart_rx_frame_chk.sv
module uart_rx_frame_chk
    import urx_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       fifo_en,
    input  logic       stop2,
    input  logic       par_en,
    input  logic       even_sel,
    input  logic       stick_sel,
    input  logic       nine_bit,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_ovr,
    output logic       rd_valid,
    output logic       buf_full
);

    localparam int FW = $clog2(DEPTH + 1);

    logic          rx_s;
    logic          wr_stb;
    rx_entry_t     wr_ent;
    rx_entry_t     rd_ent;
    logic [FW-1:0] fill;
    logic          unused_stop2;

    // only the first stop bit is ever examined on receive
    assign unused_stop2 = stop2;

    urx_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rx_s)
    );

    urx_frame_fsm #(
        .OVS (OVS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rx        (rx_s),
        .par_en    (par_en),
        .even_sel  (even_sel),
        .stick_sel (stick_sel),
        .nine_bit  (nine_bit),
        .push      (wr_stb),
        .entry     (wr_ent)
    );

    urx_rxbuf #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .push    (wr_stb),
        .din     (wr_ent),
        .pop     (rd_en),
        .dout    (rd_ent),
        .valid   (rd_valid),
        .full    (buf_full),
        .ovr     (rd_ovr),
        .fill    (fill)
    );

    assign rd_data = rd_ent.data;
    assign rd_perr = rd_ent.perr;
    assign rd_ferr = rd_ent.ferr;

endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
    parameter int DEPTH = 8,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          buf_full,
    input logic          rd_ovr,
    input logic          wr_stb,
    input logic [FW-1:0] fill
);

    p_reset_empty_r12: assert property (@(posedge clk)
        !rst_n |=> (fill == '0 && !rd_ovr));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    p_single_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && fill != '0) |-> buf_full);

    p_valid_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (fill != '0));

    p_pop_shrinks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid && !wr_stb) |=> (fill == $past(fill) - 1'b1));

    p_store_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !buf_full && !(rd_en && rd_valid)) |=> (fill == $past(fill) + 1'b1));

    p_drop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && buf_full && !(rd_en && rd_valid)) |=> (rd_ovr && fill == $past(fill)));

    p_swap_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && buf_full && rd_en && rd_valid) |=> (!rd_ovr && fill == $past(fill)));

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid) |=> !rd_ovr);

endmodule

bind uart_rx_frame_chk urx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .buf_full (buf_full),
    .rd_ovr   (rd_ovr),
    .wr_stb   (wr_stb),
    .fill     (fill)
);

// File: tb/sim_uart_rx_frame_chk.sv
module sim_uart_rx_frame_chk;

    localparam int DEPTH = 8;
    localparam int BITC  = 64;

    logic       clk = 1'b0;
    logic       rst_n, tick16, rxd, fifo_en, stop2, par_en, even_sel, stick_sel, nine_bit, rd_en;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_ovr, rd_valid, buf_full;

    always #4 clk = ~clk;

    uart_rx_frame_chk #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .fifo_en(fifo_en),
        .stop2(stop2), .par_en(par_en), .even_sel(even_sel), .stick_sel(stick_sel),
        .nine_bit(nine_bit), .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_ovr(rd_ovr), .rd_valid(rd_valid), .buf_full(buf_full)
    );

    typedef struct {
        logic [7:0] d;
        bit         pe;
        bit         fe;
    } ment_t;

    ment_t q[$];
    bit    mov;
    bit    cmp_en = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R12";
    int    compared = 0;
    int    mismatched = 0;

    // oversampling enable: one cycle in four
    initial begin
        int tc = 0;
        tick16 = 1'b0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 4;
            tick16 = (tc == 0);
        end
    end

    function automatic int cap_now();
        return fifo_en ? DEPTH : 1;
    endfunction

    task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        ment_t h;
        bit    v;
        v = (q.size() != 0);
        if (v) h = q[0];
        else begin h.d = 8'h00; h.pe = 0; h.fe = 0; end
        chk(cur_req, rd_valid == v, "rd_valid", rd_valid, v);
        chk(cur_req, rd_data == h.d, "rd_data", rd_data, h.d);
        chk(cur_req, rd_perr == h.pe, "rd_perr", rd_perr, h.pe);
        chk(cur_req, rd_ferr == h.fe, "rd_ferr", rd_ferr, h.fe);
        chk(cur_req, rd_ovr == mov, "rd_ovr", rd_ovr, mov);
        chk(cur_req, buf_full == (q.size() >= cap_now()), "buf_full", buf_full, q.size() >= cap_now());
    endtask

    always @(posedge clk) begin
        #2;
        if (cmp_en && rst_n) compare_all();
    end

    function automatic bit exp_perr(input logic [7:0] d, input logic pb);
        if (nine_bit) return pb;
        if (!par_en) return 1'b0;
        if (stick_sel) return pb != !even_sel;
        return even_sel ? (^{d, pb}) : !(^{d, pb});
    endfunction

    function automatic logic good_pb(input logic [7:0] d);
        if (nine_bit) return 1'b0;
        if (stick_sel) return !even_sel;
        return even_sel ? (^d) : !(^d);
    endfunction

    task automatic drive_bit(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pb, input logic stopv,
                              input int stop_len, input int idle);
        ment_t e;
        bit    slot;
        cmp_en = 1'b0;
        slot = par_en | nine_bit;
        drive_bit(1'b0, BITC);
        for (int i = 0; i < 8; i++) drive_bit(d[i], BITC);
        if (slot) drive_bit(pb, BITC);
        drive_bit(stopv, stop_len);
        rxd = 1'b1;
        e.d = d;
        e.pe = slot ? exp_perr(d, pb) : 1'b0;
        e.fe = !stopv;
        if (q.size() < cap_now()) q.push_back(e);
        else mov = 1'b1;
        repeat (idle) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic good_frame(input logic [7:0] d);
        send_frame(d, good_pb(d), 1'b1, BITC, 24);
    endtask

    task automatic read_one();
        rd_en = 1'b1;
        if (q.size() != 0) begin
            void'(q.pop_front());
            mov = 1'b0;
        end
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() != 0) read_one();
        repeat (4) @(negedge clk);
    endtask

    task automatic reset_dut();
        cmp_en = 1'b0;
        rst_n = 1'b0;
        rd_en = 1'b0;
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        q.delete();
        mov = 1'b0;
        cur_req = "R12";
        chk("R12", !rd_valid && !buf_full && !rd_ovr, "reset outputs",
            {rd_valid, buf_full, rd_ovr}, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int kept = 0;
        int dropped = 0;
        rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0;
        fifo_en = 1'b1; stop2 = 1'b0; par_en = 1'b0; even_sel = 1'b0;
        stick_sel = 1'b0; nine_bit = 1'b0;
        reset_dut();

        // R3 / R4: no slot, LSB-first assembly
        cur_req = "R3";
        good_frame(8'hA5); good_frame(8'h01); good_frame(8'h80);
        cur_req = "R4";
        good_frame(8'h3C);
        drain();

        // R1: short low pulse is a false start
        cur_req = "R1";
        drive_bit(1'b0, 16);
        drive_bit(1'b1, 400);

        // R5: computed parity
        cur_req = "R5";
        par_en = 1'b1; even_sel = 1'b0;
        good_frame(8'h5A);
        send_frame(8'h5B, !good_pb(8'h5B), 1'b1, BITC, 24);
        even_sel = 1'b1;
        good_frame(8'h37);
        send_frame(8'h37, !good_pb(8'h37), 1'b1, BITC, 24);
        drain();

        // R6: fixed-level parity
        cur_req = "R6";
        stick_sel = 1'b1; even_sel = 1'b0;
        send_frame(8'h12, 1'b1, 1'b1, BITC, 24);
        send_frame(8'h12, 1'b0, 1'b1, BITC, 24);
        even_sel = 1'b1;
        send_frame(8'hE7, 1'b0, 1'b1, BITC, 24);
        send_frame(8'hE7, 1'b1, 1'b1, BITC, 24);
        drain();

        // R7: address marker overrides parity settings
        cur_req = "R7";
        stick_sel = 1'b0; even_sel = 1'b1; nine_bit = 1'b1;
        send_frame(8'h44, 1'b1, 1'b1, BITC, 24);
        send_frame(8'h45, 1'b0, 1'b1, BITC, 24);
        par_en = 1'b0;
        send_frame(8'h46, 1'b1, 1'b1, BITC, 24);
        drain();
        nine_bit = 1'b0;

        // R8: two-stop setting ignored, back-to-back single stop bits
        cur_req = "R8";
        stop2 = 1'b1;
        send_frame(8'hC3, 1'b0, 1'b1, BITC, 0);
        send_frame(8'h69, 1'b0, 1'b1, BITC, 0);
        send_frame(8'hF0, 1'b0, 1'b1, BITC, 24);
        drain();
        stop2 = 1'b0;

        // R9: framing error and re-arm on high line
        cur_req = "R9";
        send_frame(8'h81, 1'b0, 1'b0, 3 * BITC, 24);
        good_frame(8'h7E);
        drain();

        // R10: queue overrun
        cur_req = "R10";
        for (int i = 0; i <= DEPTH; i++) good_frame(8'(8'h20 + i));
        read_one();
        drain();

        // R2: holding mode keeps one character
        cur_req = "R2";
        fifo_en = 1'b0;
        good_frame(8'h99);
        good_frame(8'h66);
        drain();

        // R11: sweep a read pulse across the store window of a full holding entry
        cur_req = "R11";
        for (int k = 24; k <= 56; k += 2) begin
            reset_dut();
            fifo_en = 1'b0;
            cur_req = "R11";
            good_frame(8'hA1);
            cmp_en = 1'b0;
            drive_bit(1'b0, BITC);
            for (int i = 0; i < 8; i++) drive_bit(k[i+1] ^ 1'b1, BITC);
            rxd = 1'b1;
            repeat (k) @(negedge clk);
            chk("R11", rd_valid && rd_data == 8'hA1, "head before read", rd_data, 8'hA1);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            repeat (BITC - k - 1 + 32) @(negedge clk);
            chk("R11", !rd_ovr, "overrun after read", rd_ovr, 0);
            if (rd_valid) begin
                kept++;
                chk("R11", rd_data == ~8'(k >> 1), "kept byte", rd_data, ~8'(k >> 1));
            end else begin
                dropped++;
            end
        end
        chk("R11", kept > 0, "trials keeping new byte", kept, 1);
        chk("R11", dropped > 0, "trials dropping new byte", dropped, 1);

        reset_dut();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule